// File: doc/BRIEF.md
# Latch-Based Dual-Port Register File

A four-word by four-bit storage array built from level-sensitive latches. It has one write port and one read port that work independently, so one word can be stored while another is read in the same interval. A low level on the write enable opens the latches of the addressed word. While it stays low, that word follows the data inputs. When the enable goes high, the word keeps the last value it saw.

The read side selects a word with its own address and drives it on the output while the read enable is low. When the read enable is high the outputs float. That lets several arrays share one output bus, with their read enables driven so that only one is low at a time. The block has no clock. An active-low asynchronous reset clears every word, so the contents are known at start-up.

Top module: `rf_latch_2p`

## Requirements
- R1: While rst_ni is 0, all words read as 0000, even with a write enabled. Reset has priority over writes.
- R2: Address buses are plain binary word indexes with bit 1 as the MSB: 00 is word 0, 01 word 1, 10 word 2, 11 word 3. The same coding applies to wr_addr_i and rd_addr_i.
- R3: While wr_en_ni is 0, the word at wr_addr_i takes the value on d_i. Every other word is unchanged.
- R4: While wr_en_ni is 1, changes on d_i and wr_addr_i have no effect on any stored word.
- R5: While rd_en_ni is 0, q_o shows the stored word at rd_addr_i, not inverted.
- R6: While rd_en_ni is 1, all bits of q_o are high impedance (z).
- R7: A read at one address while a different address is being written returns the stored value of the word being read. The word a read selects does not depend on wr_en_ni.
- R8: When the word being read is also being written (wr_en_ni 0, equal addresses), q_o follows d_i combinationally, including changes of d_i during the write.
- R9: After wr_en_ni rises, the written word keeps the last value d_i had while the enable was low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_ni | input | 1 | Asynchronous active-low clear of all words |
| wr_en_ni | input | 1 | Active-low write enable, opens the addressed word |
| wr_addr_i | input | 2 | Write word index; hold it stable while wr_en_ni is low |
| d_i | input | 4 | Write data |
| rd_en_ni | input | 1 | Active-low read enable; high floats q_o |
| rd_addr_i | input | 2 | Read word index |
| q_o | output | 4 | Three-state read data |

## Verification
Every result is combinational, so it is due in the same cycle as the stimulus that causes it, with no register delay. The bench applies addresses, data and enables just after a rising edge of its pacing clock and lowers the write enable one nanosecond later. It samples q_o at the next falling edge, while the write pulse is still open, so write-through is seen as it happens. The write enable is raised only after that sample, and the effect on stored data is checked on the following cycle. Floating outputs are compared with four-state equality against z.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  parameter int unsigned RF_WORDS = 4;
  parameter int unsigned RF_WIDTH = 4;
endpackage

// File: rtl/rf_wr_decode.sv
`timescale 1ns/1ps
module rf_wr_decode #(
  parameter int unsigned WORDS = 4,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic            wr_en_ni,
  input  logic [AW-1:0]   wr_addr_i,
  output logic [WORDS-1:0] wr_gate_o
);
  for (genvar k = 0; k < WORDS; k++) begin : g_dec
    assign wr_gate_o[k] = !wr_en_ni && (wr_addr_i == AW'(k));
  end
endmodule

// File: rtl/rf_latch_array.sv
`timescale 1ns/1ps
module rf_latch_array #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned WIDTH = 4
) (
  input  logic                         rst_ni,
  input  logic                         wr_en_ni,
  input  logic [WORDS-1:0]             wr_gate_i,
  input  logic [WIDTH-1:0]             d_i,
  output logic [WORDS-1:0][WIDTH-1:0]  words_o
);
  for (genvar k = 0; k < WORDS; k++) begin : g_word
    logic [WIDTH-1:0] word_q;
    always_latch begin
      if (!rst_ni)            word_q = '0;
      else if (wr_gate_i[k])  word_q = d_i;
    end
    assign words_o[k] = word_q;
  end

  always_comb begin
    p_gate_onehot_r2: assert ($onehot0(wr_gate_i))
      else $error("more than one word open for writing");
    p_gate_idle_r4: assert (wr_en_ni !== 1'b1 || wr_gate_i == '0)
      else $error("word open while write disabled");
    for (int k = 0; k < WORDS; k++) begin
      p_reset_clear_r1: assert (rst_ni !== 1'b0 || words_o[k] == '0)
        else $error("word not cleared under reset");
    end
  end
endmodule

// File: rtl/rf_rd_port.sv
`timescale 1ns/1ps
module rf_rd_port #(
  parameter int unsigned WORDS = 4,
  parameter int unsigned WIDTH = 4,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic                         rd_en_ni,
  input  logic [AW-1:0]                rd_addr_i,
  input  logic [WORDS-1:0][WIDTH-1:0]  words_i,
  output logic [WIDTH-1:0]             data_o,
  output logic                         oe_o
);
  assign data_o = words_i[rd_addr_i];
  assign oe_o   = !rd_en_ni;
endmodule

// File: rtl/rf_latch_2p.sv
`timescale 1ns/1ps
module rf_latch_2p
  import rf_pkg::*;
#(
  parameter int unsigned WORDS = RF_WORDS,
  parameter int unsigned WIDTH = RF_WIDTH,
  localparam int unsigned AW = $clog2(WORDS)
) (
  input  logic             rst_ni,
  input  logic             wr_en_ni,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] d_i,
  input  logic             rd_en_ni,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WORDS-1:0]            wr_gate;
  logic [WORDS-1:0][WIDTH-1:0] words;
  logic [WIDTH-1:0]            rd_data;
  logic                        rd_oe;

  rf_wr_decode #(.WORDS(WORDS)) u_dec (
    .wr_en_ni (wr_en_ni),
    .wr_addr_i(wr_addr_i),
    .wr_gate_o(wr_gate)
  );

  rf_latch_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u_arr (
    .rst_ni   (rst_ni),
    .wr_en_ni (wr_en_ni),
    .wr_gate_i(wr_gate),
    .d_i      (d_i),
    .words_o  (words)
  );

  rf_rd_port #(.WORDS(WORDS), .WIDTH(WIDTH)) u_rd (
    .rd_en_ni (rd_en_ni),
    .rd_addr_i(rd_addr_i),
    .words_i  (words),
    .data_o   (rd_data),
    .oe_o     (rd_oe)
  );

  assign q_o = rd_oe ? rd_data : 'z;

  // same-word write must pass straight to the bus
  always_comb begin
    p_write_through_r8: assert (!(rst_ni === 1'b1 && wr_en_ni === 1'b0 &&
                                  rd_en_ni === 1'b0 && rd_addr_i == wr_addr_i)
                                || q_o === d_i)
      else $error("write-through mismatch");
  end
endmodule

// File: tb/sim_rf_latch_2p.sv
`timescale 1ns/1ps
module sim_rf_latch_2p;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_ni = 1'b1;
  logic [1:0] wr_addr = '0;
  logic [3:0] d = '0;
  logic       rd_en_ni = 1'b1;
  logic [1:0] rd_addr = '0;
  wire  [3:0] q;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [3:0] mdl [4];

  always #4 clk = ~clk;

  rf_latch_2p u0 (
    .rst_ni(rst_ni), .wr_en_ni(wr_en_ni), .wr_addr_i(wr_addr), .d_i(d),
    .rd_en_ni(rd_en_ni), .rd_addr_i(rd_addr), .q_o(q)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: q_o=%b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_q(input bit we, input logic [1:0] wa,
                                       input logic [3:0] dv, input bit ren,
                                       input logic [1:0] ra);
    if (ren) return 4'bzzzz;
    if (we && wa == ra) return dv;
    return mdl[ra];
  endfunction

  // one access: inputs after rise, write pulse opened 1ns later, sample at fall
  task automatic step(input bit we, input logic [1:0] wa, input logic [3:0] dv,
                      input bit ren, input logic [1:0] ra, input string tag);
    logic [3:0] e;
    @(posedge clk);
    wr_addr = wa; d = dv; rd_en_ni = ren; rd_addr = ra;
    #1 wr_en_ni = ~we;
    @(negedge clk);
    e = exp_q(we, wa, dv, ren, ra);
    chk(tag, q, e);
    #1 wr_en_ni = 1'b1;
    if (we) mdl[wa] = dv;
  endtask

  task automatic reset_pulse();
    @(posedge clk);
    rst_ni = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(posedge clk);
      wr_addr = 2'd2; d = 4'hf; rd_en_ni = 1'b0; rd_addr = 2'(k);
      #1 wr_en_ni = 1'b0;
      @(negedge clk);
      chk("R1 reset clears and beats write", q, 4'h0);
      #1 wr_en_ni = 1'b1;
    end
    for (int k = 0; k < 4; k++) mdl[k] = 4'h0;
    @(posedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < 4; k++) mdl[k] = 4'h0;
    reset_pulse();

    // R6 float, R5 reads after reset
    step(0, 2'd0, 4'h0, 1, 2'd1, "R6 outputs float");
    step(0, 2'd0, 4'h0, 0, 2'd3, "R5 read cleared word");

    // R2 R3: distinct patterns per index
    step(1, 2'b00, 4'h3, 1, 2'd0, "R6 float during write");
    step(1, 2'b01, 4'h5, 1, 2'd0, "R3 write word1");
    step(1, 2'b10, 4'ha, 1, 2'd0, "R3 write word2");
    step(1, 2'b11, 4'hc, 1, 2'd0, "R3 write word3");
    for (int k = 0; k < 4; k++) step(0, 2'd0, 4'h0, 0, 2'(k), "R2 binary word index");

    // R4: data and address move with write disabled
    for (int k = 0; k < 4; k++) step(0, 2'(3 - k), 4'h9 ^ 4'(k), 0, 2'(k), "R4 no write when disabled");

    // R7: read other word during write
    step(1, 2'd0, 4'h6, 0, 2'd2, "R7 read during write elsewhere");
    step(1, 2'd3, 4'h1, 0, 2'd1, "R7 read during write elsewhere");
    step(0, 2'd0, 4'h0, 0, 2'd0, "R3 word0 updated");
    step(0, 2'd0, 4'h0, 0, 2'd3, "R3 word3 updated");

    // R8: write-through following data changes, then R9 hold
    @(posedge clk);
    wr_addr = 2'd1; rd_addr = 2'd1; rd_en_ni = 1'b0; d = 4'h2;
    #1 wr_en_ni = 1'b0;
    #1 chk("R8 write-through", q, 4'h2);
    d = 4'hd;
    #1 chk("R8 write-through follows d", q, 4'hd);
    d = 4'h7;
    #1 chk("R8 write-through follows d", q, 4'h7);
    wr_en_ni = 1'b1; mdl[1] = 4'h7;
    #1 d = 4'h0;
    #1 chk("R9 hold after enable rises", q, 4'h7);
    wr_addr = 2'd2; d = 4'hb;
    #1 chk("R9 hold with address moved", q, 4'h7);
    step(0, 2'd0, 4'h0, 0, 2'd2, "R4 neighbour untouched");

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      bit we, ren;
      logic [1:0] wa, ra;
      logic [3:0] dv;
      we  = ($urandom % 3) != 0;
      ren = ($urandom % 5) == 0;
      wa  = 2'($urandom);
      ra  = ($urandom % 3 == 0) ? wa : 2'($urandom);
      dv  = 4'($urandom);
      step(we, wa, dv, ren, ra, "R7 R8 random access");
    end

    // reset mid-run then readback
    reset_pulse();
    for (int k = 0; k < 4; k++) step(0, 2'd0, 4'h0, 0, 2'(k), "R1 cleared after reset");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule